// File: doc/BRIEF.md
# UART Register Block with Interrupt Combining

This block is the software-visible face of a serial port. A host bus reaches it with word-aligned byte addresses inside a 4 KiB window. The block holds the port's configuration: the baud divisors, line and control settings, the FIFO level select, the low-power divisor and the DMA enables. A data write sends a byte to the serial transmitter. A data read takes the oldest entry from the receive FIFO. The status flags are sampled from the FIFOs, and a read-only identification window sits at the top of the region.

Two interrupt sources, transmit and receive, are kept in a raw status vector. Software can mask that vector and clear it bit by bit. One registered interrupt line is high whenever any unmasked raw bit is set. The receive FIFO and the transmitter are outside the block. They connect through a pop strobe, a level-hit pulse, four status inputs and a byte strobe.

Top module: `uart_regblock`

## Requirements
- R1: After reset, the FIFO level select reads 0x12, control reads 0x300, flags read 0x90, every other register reads zero and `irq` is low.
- R2: The configuration registers read back the last value written, truncated to their width: low-power divisor 8 bits (word 8), integer divisor 16 bits (word 9), fractional divisor 6 bits (word 10), line control 8 bits (word 11), control 16 bits (word 12), level select 6 bits (word 13), mask 11 bits (word 14), DMA control 3 bits (word 18).
- R3: A write to word 0 drives `tx_strobe` high for exactly the following cycle, with `tx_byte` equal to the low eight write bits. The same write sets raw status bit 5 (transmit, value 0x20).
- R4: A read of word 0 returns the 12-bit `rx_data` and drives `rx_pop` in that same cycle. It also latches `rx_data[11:8]` into the receive status at word 1. Any write to word 1 clears that status to zero.
- R5: A one-cycle pulse on `rx_irq_set` sets raw status bit 4 (receive, value 0x10).
- R6: A write to word 17 clears each raw status bit written as one and leaves the other bits unchanged. When a receive set arrives in the same cycle, the set wins.
- R7: Word 15 reads the raw status, and word 16 reads the raw status AND the mask. `irq` is the OR of that masked status, registered, so it follows a change of raw status or mask one cycle later.
- R8: Word 6 reads {tx_empty, rx_full, tx_full, rx_empty} at bits 7 to 4, sampled one cycle late. Writes to word 6 have no effect.
- R9: Byte offsets 0xFE0 to 0xFFC read eight ID bytes in turn. The default set is 11 10 14 00 0D F0 05 B1. With `ID_ALT`=1 the set is 11 00 18 01 0D F0 05 B1.
- R10: Undefined words read zero and ignore writes. Word 17 reads zero. Words 15 and 16 and the ID window ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_strobe | output | 1 | One-cycle pulse handing a byte to the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| rx_data | input | 12 | Head of the receive FIFO: error bits 11:8, data 7:0 |
| rx_pop | output | 1 | Removes the FIFO head during a data read |
| rx_irq_set | input | 1 | Receive level reached, sets the receive raw bit |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies. One has the default parameters: 12-bit address, 11-bit interrupt vector and the standard ID set. The other is identical except `ID_ALT`=1, so both ID tables are read back at every offset of the window. With the default field widths, writes of over-wide values show each register's truncation. The 11-bit mask lets the bench check that the upper, unused raw bits never raise the line.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

    localparam int DATA_W  = 32;
    localparam int ERR_W   = 4;
    localparam int BYTE_W  = 8;
    localparam int RX_W    = BYTE_W + ERR_W;
    localparam int ILPR_W  = 8;
    localparam int IBRD_W  = 16;
    localparam int FBRD_W  = 6;
    localparam int LCR_W   = 8;
    localparam int CTRL_W  = 16;
    localparam int IFLS_W  = 6;
    localparam int IRQ_W   = 11;
    localparam int DMA_W   = 3;
    localparam int FLAG_W  = 8;
    localparam int ID_N    = 8;
    localparam int ID_IW   = $clog2(ID_N);

    localparam int IRQ_TX_BIT = 5;
    localparam int IRQ_RX_BIT = 4;

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
    localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;
    localparam logic [FLAG_W-1:0] FLAG_RST = 8'h90;

    typedef enum logic [3:0] {
        SEL_DATA, SEL_ESTAT, SEL_FLAG, SEL_LPDIV, SEL_IDIV, SEL_FDIV,
        SEL_LINE, SEL_CTRL, SEL_LEVEL, SEL_MASK, SEL_RAW, SEL_MSKD,
        SEL_ICLR, SEL_DMA, SEL_ID, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [ILPR_W-1:0] lpdiv;
        logic [IBRD_W-1:0] idiv;
        logic [FBRD_W-1:0] fdiv;
        logic [LCR_W-1:0]  line;
        logic [CTRL_W-1:0] ctrl;
        logic [IFLS_W-1:0] level;
        logic [DMA_W-1:0]  dma;
    } cfg_t;

    function automatic logic [BYTE_W-1:0] id_byte(input logic alt, input logic [ID_IW-1:0] idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            3'd0: b = 8'h11;
            3'd1: b = alt ? 8'h00 : 8'h10;
            3'd2: b = alt ? 8'h18 : 8'h14;
            3'd3: b = alt ? 8'h01 : 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [ID_IW-1:0]  id_idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] ID_BASE = WORD_W'((1 << WORD_W) - ID_N);

    logic [WORD_W-1:0] word;

    assign word   = addr[ADDR_W-1:2];
    assign id_idx = word[ID_IW-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (word >= ID_BASE) begin
            sel = SEL_ID;
        end else begin
            case (word)
                WORD_W'(0):  sel = SEL_DATA;
                WORD_W'(1):  sel = SEL_ESTAT;
                WORD_W'(6):  sel = SEL_FLAG;
                WORD_W'(8):  sel = SEL_LPDIV;
                WORD_W'(9):  sel = SEL_IDIV;
                WORD_W'(10): sel = SEL_FDIV;
                WORD_W'(11): sel = SEL_LINE;
                WORD_W'(12): sel = SEL_CTRL;
                WORD_W'(13): sel = SEL_LEVEL;
                WORD_W'(14): sel = SEL_MASK;
                WORD_W'(15): sel = SEL_RAW;
                WORD_W'(16): sel = SEL_MSKD;
                WORD_W'(17): sel = SEL_ICLR;
                WORD_W'(18): sel = SEL_DMA;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] raw_n;

    always_comb begin
        raw_n = raw;
        if (clr_en) raw_n = raw_n & ~clr_vec;
        raw_n = raw_n | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            raw <= raw_n;
            if (mask_we) mask <= mask_in;
            irq <= |(raw & mask);
        end
    end
endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom
    import uart_reg_pkg::*;
#(
    parameter int ID_ALT = 0
) (
    input  logic [ID_IW-1:0]  idx,
    output logic [BYTE_W-1:0] data
);
    generate
        if (ID_ALT != 0) begin : g_alt
            assign data = id_byte(1'b1, idx);
        end else begin : g_std
            assign data = id_byte(1'b0, idx);
        end
    endgenerate
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
    import uart_reg_pkg::*;
#(
    parameter int ID_ALT = 0,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic [RX_W-1:0]   rx_data,
    output logic              rx_pop,
    input  logic              rx_irq_set,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    output logic              irq
);
    reg_sel_e          sel;
    logic [ID_IW-1:0]  id_idx;
    logic [BYTE_W-1:0] id_data;
    cfg_t              cfg_q;
    logic [ERR_W-1:0]  estat_q;
    logic [FLAG_W-1:0] flags_q;
    logic [IRQ_W-1:0]  raw_q;
    logic [IRQ_W-1:0]  mask_q;
    logic [IRQ_W-1:0]  set_vec;
    logic              wr_data;

    uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    uart_id_rom #(.ID_ALT(ID_ALT)) u_id (
        .idx  (id_idx),
        .data (id_data)
    );

    assign wr_data = bus_wr && (sel == SEL_DATA);

    always_comb begin
        set_vec = '0;
        set_vec[IRQ_TX_BIT] = wr_data;
        set_vec[IRQ_RX_BIT] = rx_irq_set;
    end

    uart_irq_core #(.W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_en  (bus_wr && (sel == SEL_ICLR)),
        .clr_vec (bus_wdata[IRQ_W-1:0]),
        .mask_we (bus_wr && (sel == SEL_MASK)),
        .mask_in (bus_wdata[IRQ_W-1:0]),
        .raw     (raw_q),
        .mask    (mask_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            cfg_q.ctrl  <= CTRL_RST;
            cfg_q.level <= IFLS_RST;
            estat_q     <= '0;
            flags_q     <= FLAG_RST;
            tx_strobe   <= 1'b0;
            tx_byte     <= '0;
        end else begin
            flags_q   <= {tx_empty, rx_full, tx_full, rx_empty, 4'b0000};
            tx_strobe <= wr_data;
            if (wr_data) tx_byte <= bus_wdata[BYTE_W-1:0];
            if (rx_pop) estat_q <= rx_data[RX_W-1:BYTE_W];
            if (bus_wr) begin
                case (sel)
                    SEL_ESTAT: estat_q     <= '0;
                    SEL_LPDIV: cfg_q.lpdiv <= bus_wdata[ILPR_W-1:0];
                    SEL_IDIV:  cfg_q.idiv  <= bus_wdata[IBRD_W-1:0];
                    SEL_FDIV:  cfg_q.fdiv  <= bus_wdata[FBRD_W-1:0];
                    SEL_LINE:  cfg_q.line  <= bus_wdata[LCR_W-1:0];
                    SEL_CTRL:  cfg_q.ctrl  <= bus_wdata[CTRL_W-1:0];
                    SEL_LEVEL: cfg_q.level <= bus_wdata[IFLS_W-1:0];
                    SEL_DMA:   cfg_q.dma   <= bus_wdata[DMA_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign rx_pop = bus_rd && (sel == SEL_DATA);

    always_comb begin
        case (sel)
            SEL_DATA:  bus_rdata = DATA_W'(rx_data);
            SEL_ESTAT: bus_rdata = DATA_W'(estat_q);
            SEL_FLAG:  bus_rdata = DATA_W'(flags_q);
            SEL_LPDIV: bus_rdata = DATA_W'(cfg_q.lpdiv);
            SEL_IDIV:  bus_rdata = DATA_W'(cfg_q.idiv);
            SEL_FDIV:  bus_rdata = DATA_W'(cfg_q.fdiv);
            SEL_LINE:  bus_rdata = DATA_W'(cfg_q.line);
            SEL_CTRL:  bus_rdata = DATA_W'(cfg_q.ctrl);
            SEL_LEVEL: bus_rdata = DATA_W'(cfg_q.level);
            SEL_MASK:  bus_rdata = DATA_W'(mask_q);
            SEL_RAW:   bus_rdata = DATA_W'(raw_q);
            SEL_MSKD:  bus_rdata = DATA_W'(raw_q & mask_q);
            SEL_DMA:   bus_rdata = DATA_W'(cfg_q.dma);
            SEL_ID:    bus_rdata = DATA_W'(id_data);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_strobe,
    input logic              rx_pop,
    input logic              rx_irq_set,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              irq,
    input logic [IRQ_W-1:0]  raw_q,
    input logic [IRQ_W-1:0]  mask_q,
    input logic [FLAG_W-1:0] flags_q
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] ID_BASE = WORD_W'((1 << WORD_W) - ID_N);

    logic [WORD_W-1:0] w;
    logic              undef_w;
    assign w = bus_addr[ADDR_W-1:2];
    assign undef_w = (w >= WORD_W'(2) && w <= WORD_W'(5)) || w == WORD_W'(7) ||
                     w == WORD_W'(17) || (w > WORD_W'(18) && w < ID_BASE);

    // R3
    a_r3_tx_sets_raw: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |-> raw_q[IRQ_TX_BIT]);
    // R3
    a_r3_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |-> $past(bus_wr && w == WORD_W'(0)));
    // R4
    a_r4_pop_on_read: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_rd && w == WORD_W'(0)));
    // R5
    a_r5_rx_set: assert property (@(posedge clk) disable iff (rst)
        rx_irq_set |=> raw_q[IRQ_RX_BIT]);
    // R6
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && w == WORD_W'(17) && !rx_irq_set) |=> ((raw_q & $past(bus_wdata[IRQ_W-1:0])) == '0));
    // R7
    a_r7_irq_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(raw_q & mask_q))));
    // R8
    a_r8_flag_sample: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_q[7:4] == $past({tx_empty, rx_full, tx_full, rx_empty})));
    // R10
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && undef_w) |-> (bus_rdata == '0));
endmodule

bind uart_regblock uart_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_strobe  (tx_strobe),
    .rx_pop     (rx_pop),
    .rx_irq_set (rx_irq_set),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .irq        (irq),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .flags_q    (flags_q)
);

// File: tb/uart_regblock_tb.sv
module uart_regblock_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_alt;
    logic        tx_strobe, tx_strobe_alt;
    logic [7:0]  tx_byte, tx_byte_alt;
    logic [11:0] rx_data = '0;
    logic        rx_pop, rx_pop_alt;
    logic        rx_irq_set = 1'b0;
    logic        tx_empty = 1'b1, tx_full = 1'b0, rx_empty = 1'b1, rx_full = 1'b0;
    logic        irq, irq_alt;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    uart_regblock u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .rx_data(rx_data), .rx_pop(rx_pop), .rx_irq_set(rx_irq_set),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .irq(irq)
    );

    uart_regblock #(.ID_ALT(1)) u_dut_alt (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .tx_strobe(tx_strobe_alt),
        .tx_byte(tx_byte_alt), .rx_data(rx_data), .rx_pop(rx_pop_alt), .rx_irq_set(rx_irq_set),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .irq(irq_alt)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{"R2 ", 12'h020, 32'h0000_01FF, 32'h0000_00FF},
        '{"R2 ", 12'h024, 32'h0001_2345, 32'h0000_2345},
        '{"R2 ", 12'h028, 32'h0000_00FF, 32'h0000_003F},
        '{"R2 ", 12'h02C, 32'h0000_01AB, 32'h0000_00AB},
        '{"R2 ", 12'h030, 32'hFFFF_8001, 32'h0000_8001},
        '{"R2 ", 12'h034, 32'h0000_007F, 32'h0000_003F},
        '{"R2 ", 12'h048, 32'h0000_000F, 32'h0000_0007},
        '{"R8 ", 12'h018, 32'h0000_00FF, 32'h0000_0090},
        '{"R10", 12'h03C, 32'h0000_07FF, 32'h0000_0000},
        '{"R10", 12'h040, 32'h0000_07FF, 32'h0000_0000},
        '{"R10", 12'h044, 32'h0000_0000, 32'h0000_0000},
        '{"R10", 12'h008, 32'hDEAD_BEEF, 32'h0000_0000},
        '{"R10", 12'h100, 32'hDEAD_BEEF, 32'h0000_0000},
        '{"R10", 12'hFE0, 32'h0000_0000, 32'h0000_0011}
    };

    localparam logic [7:0] ID_STD [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    localparam logic [7:0] ID_ALT [8] = '{8'h11, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic pop);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; pop = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        p;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h034, d, p); check("R1 level", d, 32'h12);
        rd(12'h030, d, p); check("R1 ctrl", d, 32'h300);
        rd(12'h018, d, p); check("R1 flags", d, 32'h90);
        rd(12'h024, d, p); check("R1 idiv", d, 32'h0);
        rd(12'h03C, d, p); check("R1 raw", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].wdata);
            rd(VEC[i].addr, d, p);
            check(string'(VEC[i].tag), d, VEC[i].expect_rd);
        end

        // R9 both ID sets
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_addr = 12'hFE0 + 12'(4 * i); bus_rd = 1'b1;
            #1;
            check("R9 std", bus_rdata, {24'b0, ID_STD[i]});
            check("R9 alt", rdata_alt, {24'b0, ID_ALT[i]});
            @(negedge clk);
            bus_rd = 1'b0;
        end

        // R3 data write -> strobe, byte, raw tx bit
        wr(12'h000, 32'h0000_01A5);
        check("R3 strobe", {31'b0, tx_strobe}, 32'h1);
        check("R3 byte", {24'b0, tx_byte}, 32'hA5);
        @(negedge clk);
        check("R3 strobe pulse", {31'b0, tx_strobe}, 32'h0);
        rd(12'h03C, d, p); check("R3 raw", d, 32'h20);
        check("R7 masked off", {31'b0, irq}, 32'h0);

        // R7 mask -> irq one cycle later
        wr(12'h038, 32'h0000_0020);
        check("R7 irq lag", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        rd(12'h040, d, p); check("R7 masked", d, 32'h20);
        rd(12'h038, d, p); check("R2 mask", d, 32'h20);

        // R6 clear
        wr(12'h044, 32'h0000_0020);
        check("R6 irq lag", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R6 irq low", {31'b0, irq}, 32'h0);
        rd(12'h03C, d, p); check("R6 raw cleared", d, 32'h0);

        // R5 receive set
        @(negedge clk); rx_irq_set = 1'b1;
        @(negedge clk); rx_irq_set = 1'b0;
        rd(12'h03C, d, p); check("R5 raw rx", d, 32'h10);
        rd(12'h040, d, p); check("R7 masked rx off", d, 32'h0);
        check("R7 irq rx masked", {31'b0, irq}, 32'h0);
        // R6 set beats clear in same cycle
        @(negedge clk);
        bus_addr = 12'h044; bus_wdata = 32'h10; bus_wr = 1'b1; rx_irq_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_irq_set = 1'b0;
        rd(12'h03C, d, p); check("R6 set wins", d, 32'h10);
        wr(12'h044, 32'h0000_0000);
        rd(12'h03C, d, p); check("R6 zero bits kept", d, 32'h10);
        wr(12'h044, 32'h0000_07FF);
        rd(12'h03C, d, p); check("R6 all cleared", d, 32'h0);

        // R4 data read, pop, error capture, error clear
        rx_data = 12'h5C3;
        rd(12'h000, d, p);
        check("R4 data", d, 32'h5C3);
        check("R4 pop", {31'b0, p}, 32'h1);
        rd(12'h004, d, p); check("R4 estat", d, 32'h5);
        check("R4 no pop", {31'b0, p}, 32'h0);
        wr(12'h004, 32'h0);
        rd(12'h004, d, p); check("R4 estat clr", d, 32'h0);

        // R8 flags sampled one cycle late
        @(negedge clk);
        tx_empty = 1'b0; rx_full = 1'b1; tx_full = 1'b1; rx_empty = 1'b0;
        bus_addr = 12'h018; bus_rd = 1'b1;
        #1 check("R8 before edge", bus_rdata, 32'h90);
        @(negedge clk);
        check("R8 after edge", bus_rdata, 32'h60);
        bus_rd = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule